// File: doc/BRIEF.md
# Bit-Order Selectable Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial frames on one line. It takes each byte from the read port of a transmit queue through a valid/ready handshake. It then sends a low start bit, the eight data bits, an optional multiprocessor bit and a high stop bit. The line stays high while the block is idle.

Three control inputs set the shape of a frame. The first picks whether the least or the most significant data bit goes out first. A two-bit ratio code picks 4, 8 or 16 base-clock cycles per serial bit. A format enable, together with a bit value, adds a multiprocessor bit after the data. The block takes a copy of all three controls when it accepts a byte, so a change during a frame only applies from the next frame. The ratio code 11 is invalid. While it is present, the block raises an error flag and accepts no new byte.

The system normally ties the control inputs to a control register. It clocks the block with the base clock, which runs at the chosen multiple of the bit rate.

Top module: `uart_order_tx`

## Requirements
- R1: After reset and whenever no frame is in progress, tx_out is 1, tx_busy is 0, and with fifo_valid low no frame starts.
- R2: A byte is accepted on a clock edge where fifo_valid and fifo_ready are both 1. From that edge, tx_out is 0 (the start bit) for one bit time and tx_busy is 1.
- R3: With cfg_msb_first = 0, the data bits follow the start bit in order bit 0 through bit 7.
- R4: With cfg_msb_first = 1, the data bits follow the start bit in order bit 7 through bit 0.
- R5: cfg_ratio = 00, 01 and 10 give a bit time of 4, 8 and 16 clock cycles respectively, and every bit of the frame lasts exactly that long.
- R6: cfg_ratio = 11 is invalid. While it is present, cfg_error is 1, fifo_ready is 0, no frame starts and tx_out stays 1. cfg_error is 0 for the other codes.
- R7: With cfg_mp_en = 1, one extra bit carrying cfg_mp_bit is sent between data bit 8 of the frame and the stop bit, giving 11 bits. With cfg_mp_en = 0 the frame has 10 bits.
- R8: The stop bit is 1 for one full bit time. tx_busy stays 1 and fifo_ready stays 0 until the stop bit has ended. The block then returns to idle, and fifo_ready is 1 again in the cycle after the last stop-bit cycle.
- R9: cfg_msb_first, cfg_ratio, cfg_mp_en and cfg_mp_bit are captured on the accepting edge. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_valid | input | 1 | Queue presents a byte |
| fifo_data | input | 8 | Byte from the queue |
| fifo_ready | output | 1 | Block takes the byte on this edge |
| cfg_msb_first | input | 1 | 0: LSB first, 1: MSB first |
| cfg_ratio | input | 2 | Clocks per bit: 00=4, 01=8, 10=16, 11 invalid |
| cfg_mp_en | input | 1 | Add the multiprocessor bit to each frame |
| cfg_mp_bit | input | 1 | Value of the multiprocessor bit |
| tx_out | output | 1 | Serial line, idles high |
| tx_busy | output | 1 | A frame is in progress |
| cfg_error | output | 1 | The ratio code is invalid |

## Verification
Counting from the accepting edge, bit i of the frame holds the line for the cycles i*P through i*P+P-1 after that edge, where P is the bit time. The bench samples the line at every falling edge across those cycles and compares each sample with the bit due in that cycle, worked out from the byte, the order, the format and P. The cycle N*P after the accepting edge, with N of 10 or 11, must show idle and fifo_ready high. The bench checks that cycle on its own. For the invalid ratio code it checks fifo_ready, cfg_error and the line every cycle while the code is held. For R9 it changes the controls during the start bit, and the remaining cycles must still match the captured settings.

// File: rtl/uart_order_tx.sv
module uart_order_tx #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_valid,
  input  logic [DATA_W-1:0] fifo_data,
  output logic              fifo_ready,
  input  logic              cfg_msb_first,
  input  logic [1:0]        cfg_ratio,
  input  logic              cfg_mp_en,
  input  logic              cfg_mp_bit,
  output logic              tx_out,
  output logic              tx_busy,
  output logic              cfg_error
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int LEFT_W  = $clog2(FRAME_W);

  logic               busy_q;
  logic [FRAME_W-1:0] frame_q;
  logic [LEFT_W-1:0]  left_q;
  logic [CNT_W-1:0]   tick_q, per_q, per_new;
  logic [DATA_W-1:0]  reversed, ordered;
  logic               ratio_ok, take, bit_end;

  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign reversed[i] = fifo_data[DATA_W-1-i];
  end

  assign ordered    = cfg_msb_first ? reversed : fifo_data;
  assign ratio_ok   = (cfg_ratio != 2'b11);
  assign fifo_ready = !busy_q && ratio_ok;
  assign cfg_error  = !ratio_ok;
  assign take       = fifo_valid && fifo_ready;
  assign bit_end    = (tick_q == per_q);
  assign tx_out     = busy_q ? frame_q[0] : 1'b1;
  assign tx_busy    = busy_q;

  always_comb begin
    case (cfg_ratio)
      2'b00:   per_new = CNT_W'(3);
      2'b01:   per_new = CNT_W'(7);
      default: per_new = CNT_W'(15);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      frame_q <= '1;
      left_q  <= '0;
      tick_q  <= '0;
      per_q   <= '0;
    end else if (take) begin
      busy_q  <= 1'b1;
      frame_q <= {1'b1, (cfg_mp_en ? cfg_mp_bit : 1'b1), ordered, 1'b0};
      left_q  <= cfg_mp_en ? LEFT_W'(DATA_W + 2) : LEFT_W'(DATA_W + 1);
      tick_q  <= '0;
      per_q   <= per_new;
    end else if (busy_q) begin
      if (bit_end) begin
        tick_q  <= '0;
        frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
        if (left_q == '0) busy_q <= 1'b0;
        else              left_q <= left_q - 1'b1;
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_order_tx_chk.sv
module uart_order_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fifo_valid,
  input logic       fifo_ready,
  input logic [1:0] cfg_ratio,
  input logic       tx_out,
  input logic       tx_busy,
  input logic       cfg_error
);
  assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx_out);

  assert_start_bit_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_valid && fifo_ready) |=> (tx_busy && !tx_out));

  assert_busy_only_by_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(fifo_valid && fifo_ready));

  assert_bad_ratio_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ratio == 2'b11) |-> (!fifo_ready && cfg_error));

  assert_bad_ratio_stays_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_error && !tx_busy) |=> !tx_busy);

  assert_no_accept_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> !fifo_ready);
endmodule

bind uart_order_tx uart_order_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_valid(fifo_valid), .fifo_ready(fifo_ready),
  .cfg_ratio(cfg_ratio), .tx_out(tx_out), .tx_busy(tx_busy), .cfg_error(cfg_error)
);

// File: tb/uart_order_tx_bench.sv
module uart_order_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_valid = 1'b0;
  logic [7:0] fifo_data = 8'h00;
  logic       fifo_ready;
  logic       cfg_msb_first = 1'b0;
  logic [1:0] cfg_ratio = 2'b10;
  logic       cfg_mp_en = 1'b0;
  logic       cfg_mp_bit = 1'b0;
  logic       tx_out, tx_busy, cfg_error;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  uart_order_tx u_uart_order_tx (.*);

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        finish_run();
      end
    end
  end

  task automatic send(input logic [7:0] d, input bit msb, input logic [1:0] r,
                      input bit mpe, input bit mpb, input bit disturb);
    bit exp_bits[11];
    int n, p, waited;
    string tag;
    p = 4 << r;
    n = mpe ? 11 : 10;
    exp_bits[0] = 1'b0;
    for (int j = 0; j < 8; j++) exp_bits[1+j] = msb ? d[7-j] : d[j];
    exp_bits[9] = mpe ? mpb : 1'b1;
    exp_bits[10] = 1'b1;
    tag = disturb ? "R9" : (mpe ? "R7" : (msb ? "R4" : "R3"));
    @(negedge clk);
    fifo_data = d; cfg_msb_first = msb; cfg_ratio = r;
    cfg_mp_en = mpe; cfg_mp_bit = mpb; fifo_valid = 1'b1;
    waited = 0;
    while (!fifo_ready && waited < 100) begin @(negedge clk); waited++; end
    check(fifo_ready, "R8 ready before frame", fifo_ready, 1);
    @(posedge clk);
    for (int c = 0; c < n * p; c++) begin
      @(negedge clk);
      if (c == 0) begin
        fifo_valid = 1'b0;
        if (disturb) begin
          cfg_msb_first = !msb; cfg_ratio = (r == 2'b00) ? 2'b10 : 2'b00;
          cfg_mp_en = !mpe; cfg_mp_bit = !mpb;
        end
        check(tx_busy == 1'b1, "R2 busy at start", tx_busy, 1);
      end
      if (c / p == 0)
        check(tx_out == 1'b0, "R2 start bit", tx_out, 0);
      else if (c / p == n - 1)
        check(tx_out == 1'b1 && tx_busy, "R8 stop bit", tx_out, 1);
      else
        check(tx_out == exp_bits[c / p], (c % p == 0) ? "R5 bit edge" : tag,
              tx_out, exp_bits[c / p]);
    end
    @(negedge clk);
    check(!tx_busy && tx_out, "R8 idle after stop", {tx_busy, tx_out}, 1);
    if (!disturb) check(fifo_ready == 1'b1, "R8 ready after stop", fifo_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(tx_out == 1'b1, "R1 reset line", tx_out, 1);
    check(tx_busy == 1'b0, "R1 reset busy", tx_busy, 0);
    rst_n = 1'b1;
    repeat (10) begin
      @(negedge clk);
      check(tx_out && !tx_busy, "R1 idle without valid", {tx_busy, tx_out}, 1);
    end

    for (int v = 0; v < 256; v++) send(8'(v), 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
    for (int v = 0; v < 256; v++) send(8'(v), 1'b1, 2'b00, 1'b0, 1'b0, 1'b0);

    for (int r = 0; r < 3; r++)
      for (int m = 0; m < 2; m++)
        for (int e = 0; e < 2; e++)
          for (int b = 0; b < 2; b++)
            for (int k = 0; k < 4; k++)
              send(8'(k * 83 + 1), m[0], 2'(r), e[0], b[0], 1'b0);

    send(8'h3C, 1'b0, 2'b10, 1'b1, 1'b0, 1'b1);
    send(8'hC1, 1'b1, 2'b00, 1'b0, 1'b1, 1'b1);

    @(negedge clk);
    cfg_ratio = 2'b11; fifo_valid = 1'b1; fifo_data = 8'h55;
    repeat (20) begin
      @(negedge clk);
      check(!fifo_ready, "R6 ready held off", fifo_ready, 0);
      check(cfg_error, "R6 error flag", cfg_error, 1);
      check(tx_out && !tx_busy, "R6 line idle", {tx_busy, tx_out}, 1);
    end
    fifo_valid = 1'b0;
    cfg_ratio = 2'b01;
    @(negedge clk);
    check(!cfg_error, "R6 error clear on valid code", cfg_error, 0);
    send(8'h55, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0);

    finish_run();
  end
endmodule